// File: doc/BRIEF.md
# Per-Core Compare Timer Interrupt

This block keeps one free-running counter shared by every core of a cluster and gives each core its own compare register. When the running counter equals a core's compare value, that core latches a local compare-pending flag. The flag is sent to one of the core's interrupt pins if the core has enabled it in its local mask and has routed its compare source to a pin. On that pin it is merged with whatever level the shared interrupt router already drives. Software acknowledges the interrupt by writing a new compare value, which also arms the next event.

All state is reached through a small word-addressed register port. Each request carries the index of the core that issues it. A shared window holds the stop control and the counter. An own-core window reaches the requester's local timer registers. An other-core window reaches the local registers of whichever core the requester has named in its index register, so one core can program another core's timer. The counter can be loaded only while it is stopped. Its upper word is not implemented and reads as zero.

Top module: `ctimer_top`

## Requirements
- R1: After reset the counter is 0 and running (stop bit 0), every compare register is 0xFFFFFFFF, every mask is 0x32, no compare-pending flag is set, every pin map reads 0x80000000 (routing on, pin 0) and every other-core index is 0.
- R2: Shared register 0 (address 0x00) holds the stop control in bit 0. While it is 0 the counter advances by one every clock. While it is 1 the counter holds its value. A write to it takes effect on the following edge.
- R3: The counter low word (address 0x01) takes a write only while the counter is stopped; a write made while it runs is dropped. The counter high word (address 0x02) always reads 0 and ignores writes.
- R4: In every cycle in which the counter runs and equals a core's compare value, that core's compare-pending flag is set on the next edge. It reads as bit 1 of the pending register (window offset 0). A compare value the counter has already passed fires only after the counter wraps around to it.
- R5: Writing a core's compare register (window offset 7) clears that core's pending flag on the same edge, even when a match happens in that cycle. The new value is used for matching from the next cycle on.
- R6: The 6-bit local mask (window offset 1) is changed only through the set port (offset 2, ones set bits) and the clear port (offset 3, ones clear bits). Writes to offset 1 do nothing. Mask bit 1 enables the compare source.
- R7: The compare source drives pin P of its core when the pending flag is set, mask bit 1 is set and the pin-map register (window offset 4) has routing bit 31 set with pin field bits [5:0] equal to P. A pin-map write whose pin field is NUM_PINS or more is ignored.
- R8: Each core's pin outputs are the OR of its compare source and the router levels on the matching router inputs.
- R9: A write to the other-core index (window offset 5) is ignored unless the value is below NUM_CORES. Accesses in the other-core window act on the core named by the requester's index.
- R10: The identity register (window offset 6) returns the index of the core whose registers are addressed; through the own-core window this is the requester's own index.
- R11: Address bits [4:3] select the window (0 shared, 1 own core, 2 other core, 3 none) and bits [2:0] the offset. A read returns its data with rsp_valid one cycle after the request. Unmapped offsets, set/clear ports and window 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_src | input | CORE_W | Index of the requesting core |
| req_addr | input | 5 | Word address: window [4:3], offset [2:0] |
| req_wdata | input | 32 | Write data |
| router_irq | input | NUM_CORES*NUM_PINS | Router levels, core c pin p at bit c*NUM_PINS+p |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CORES*NUM_PINS | Interrupt pins, core c pin p at bit c*NUM_PINS+p |

## Verification
Most stored state in this block shows up on the pins within a few cycles. A wrong compare value, mask bit or pin map moves or suppresses a pin edge in the cycle after the counter reaches the compare value. A wrong pending flag leaves a pin stuck high after the acknowledging compare write. A counter that runs while stopped, or loads while running, shows up as a wrong readback on the next counter read and as a pin edge at the wrong time. A wrong other-core index sends a programming write to the wrong core, and that core's pins or readback go wrong from then on.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int OFF_W    = 3;
  localparam int MASK_W   = 6;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;
  localparam int CMP_BIT  = 1;
  localparam int ROUTE_BIT = 31;
  localparam int PINF_W   = 6;

  typedef enum logic [1:0] {
    WIN_SHARED = 2'd0,
    WIN_OWN    = 2'd1,
    WIN_OTHER  = 2'd2,
    WIN_NONE   = 2'd3
  } win_e;

  localparam logic [OFF_W-1:0] SH_CFG    = 3'd0;
  localparam logic [OFF_W-1:0] SH_CNT_LO = 3'd1;
  localparam logic [OFF_W-1:0] SH_CNT_HI = 3'd2;

  localparam logic [OFF_W-1:0] LC_PEND  = 3'd0;
  localparam logic [OFF_W-1:0] LC_MASK  = 3'd1;
  localparam logic [OFF_W-1:0] LC_MSET  = 3'd2;
  localparam logic [OFF_W-1:0] LC_MCLR  = 3'd3;
  localparam logic [OFF_W-1:0] LC_MAP   = 3'd4;
  localparam logic [OFF_W-1:0] LC_OIDX  = 3'd5;
  localparam logic [OFF_W-1:0] LC_IDENT = 3'd6;
  localparam logic [OFF_W-1:0] LC_CMP   = 3'd7;

endpackage

// File: rtl/ctimer_counter.sv
module ctimer_counter
  import ctimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_stop,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic             stop_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             stop_q, stop_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             load_ok;

  assign load_ok = load_wr && stop_q;
  assign cnt_en  = load_ok || !stop_q;

  always_comb begin
    stop_d = cfg_wr ? cfg_stop : stop_q;
    if (load_ok) cnt_d = load_val;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stop_q <= stop_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign stop_o = stop_q;
  assign cnt_o  = cnt_q;

  // R2
  run_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_q |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !load_wr) |=> $stable(cnt_q));

  // R3
  load_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && load_wr) |=> cnt_q == $past(load_val));

endmodule

// File: rtl/ctimer_decode.sv
module ctimer_decode
  import ctimer_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int CORE_W    = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_we,
  input  logic [CORE_W-1:0]           req_src,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [NUM_CORES*CORE_W-1:0] oidx_flat,
  output logic                        cfg_wr,
  output logic                        load_wr,
  output logic [NUM_CORES-1:0]        core_wr,
  output logic [CORE_W-1:0]           tgt,
  output logic                        tgt_ok,
  output win_e                        win,
  output logic [OFF_W-1:0]            off
);

  logic [CORE_W-1:0] oth_idx;
  logic              src_ok;
  logic              wr_req;

  assign win    = win_e'(req_addr[ADDR_W-1:OFF_W]);
  assign off    = req_addr[OFF_W-1:0];
  assign wr_req = req_valid && req_we;
  assign src_ok = 32'(req_src) < NUM_CORES;

  always_comb begin
    oth_idx = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (32'(req_src) == c) oth_idx = oidx_flat[c*CORE_W +: CORE_W];
    end
  end

  always_comb begin
    tgt    = (win == WIN_OTHER) ? oth_idx : req_src;
    tgt_ok = src_ok && ((win == WIN_OWN) || (win == WIN_OTHER));
  end

  assign cfg_wr  = wr_req && (win == WIN_SHARED) && (off == SH_CFG);
  assign load_wr = wr_req && (win == WIN_SHARED) && (off == SH_CNT_LO);

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
      assign core_wr[c] = wr_req && tgt_ok && (32'(tgt) == c);
    end
  endgenerate

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_wr));

endmodule

// File: rtl/ctimer_core.sv
module ctimer_core
  import ctimer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_CORES = 2,
  parameter int NUM_PINS  = 6,
  parameter int PIN_W     = 3,
  parameter int CORE_W    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_run,
  input  logic [NUM_PINS-1:0] router_in,
  output logic              pend_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              route_o,
  output logic [PIN_W-1:0]  pin_o,
  output logic [CORE_W-1:0] oidx_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [NUM_PINS-1:0] pins_o
);

  logic              pend_q, pend_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              route_q, route_d;
  logic [PIN_W-1:0]  pin_q, pin_d;
  logic [CORE_W-1:0] oidx_q, oidx_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;

  logic mask_en, map_en, oidx_en, cmp_en;
  logic hit, src_on;
  logic [NUM_PINS-1:0] cmp_pins;

  assign hit     = cnt_run && (cnt_val == cmp_q);
  assign cmp_en  = wr_en && (wr_off == LC_CMP);
  assign mask_en = wr_en && ((wr_off == LC_MSET) || (wr_off == LC_MCLR));
  assign map_en  = wr_en && (wr_off == LC_MAP) &&
                   (32'(wr_data[PINF_W-1:0]) < NUM_PINS);
  assign oidx_en = wr_en && (wr_off == LC_OIDX) && (wr_data < NUM_CORES);

  always_comb begin
    pend_d  = cmp_en ? 1'b0 : (pend_q || hit);
    mask_d  = (wr_off == LC_MSET) ? (mask_q | wr_data[MASK_W-1:0])
                                  : (mask_q & ~wr_data[MASK_W-1:0]);
    route_d = wr_data[ROUTE_BIT];
    pin_d   = wr_data[PIN_W-1:0];
    oidx_d  = wr_data[CORE_W-1:0];
    cmp_d   = wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      mask_q  <= MASK_RST;
      route_q <= 1'b1;
      pin_q   <= '0;
      oidx_q  <= '0;
      cmp_q   <= '1;
    end else begin
      pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
      if (map_en) begin
        route_q <= route_d;
        pin_q   <= pin_d;
      end
      if (oidx_en) oidx_q <= oidx_d;
      if (cmp_en)  cmp_q  <= cmp_d;
    end
  end

  assign src_on   = pend_q && mask_q[CMP_BIT] && route_q;
  assign cmp_pins = src_on ? (NUM_PINS'(1) << pin_q) : '0;
  assign pins_o   = router_in | cmp_pins;

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign route_o = route_q;
  assign pin_o   = pin_q;
  assign oidx_o  = oidx_q;
  assign cmp_o   = cmp_q;

  // R4
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && cnt_val == cmp_q && !cmp_en) |=> pend_q);

  // R5
  cmp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> !pend_q);

  // R9
  oidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(oidx_q) < NUM_CORES);

  // R7
  pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && mask_q[CMP_BIT] && route_q) |-> pins_o[pin_q]);

  // R8
  router_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_o & router_in) == router_in);

endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_PINS  = 6,
  parameter int CNT_W     = 32,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_we,
  input  logic [CORE_W-1:0]             req_src,
  input  logic [4:0]                    req_addr,
  input  logic [31:0]                   req_wdata,
  input  logic [NUM_CORES*NUM_PINS-1:0] router_irq,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  output logic [NUM_CORES*NUM_PINS-1:0] cpu_irq
);

  logic             stop;
  logic [CNT_W-1:0] cnt;
  logic             cfg_wr, load_wr, tgt_ok;
  logic [NUM_CORES-1:0] core_wr;
  logic [CORE_W-1:0]    tgt;
  win_e                 win;
  logic [OFF_W-1:0]     off;
  logic [NUM_CORES*CORE_W-1:0] oidx_flat;

  logic [NUM_CORES-1:0] pend_a, route_a;
  logic [MASK_W-1:0]    mask_a  [NUM_CORES];
  logic [PIN_W-1:0]     pin_a   [NUM_CORES];
  logic [CORE_W-1:0]    oidx_a  [NUM_CORES];
  logic [CNT_W-1:0]     cmp_a   [NUM_CORES];

  logic [DATA_W-1:0] rd_word;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              rd_en;

  ctimer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_stop (req_wdata[0]),
    .load_wr  (load_wr),
    .load_val (req_wdata[CNT_W-1:0]),
    .stop_o   (stop),
    .cnt_o    (cnt)
  );

  ctimer_decode #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_src   (req_src),
    .req_addr  (req_addr),
    .oidx_flat (oidx_flat),
    .cfg_wr    (cfg_wr),
    .load_wr   (load_wr),
    .core_wr   (core_wr),
    .tgt       (tgt),
    .tgt_ok    (tgt_ok),
    .win       (win),
    .off       (off)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      ctimer_core #(
        .CNT_W     (CNT_W),
        .NUM_CORES (NUM_CORES),
        .NUM_PINS  (NUM_PINS),
        .PIN_W     (PIN_W),
        .CORE_W    (CORE_W)
      ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (core_wr[c]),
        .wr_off    (off),
        .wr_data   (req_wdata),
        .cnt_val   (cnt),
        .cnt_run   (!stop),
        .router_in (router_irq[c*NUM_PINS +: NUM_PINS]),
        .pend_o    (pend_a[c]),
        .mask_o    (mask_a[c]),
        .route_o   (route_a[c]),
        .pin_o     (pin_a[c]),
        .oidx_o    (oidx_a[c]),
        .cmp_o     (cmp_a[c]),
        .pins_o    (cpu_irq[c*NUM_PINS +: NUM_PINS])
      );
      assign oidx_flat[c*CORE_W +: CORE_W] = oidx_a[c];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (win == WIN_SHARED) begin
      if (off == SH_CFG)         rd_word = DATA_W'(stop);
      else if (off == SH_CNT_LO) rd_word = DATA_W'(cnt);
    end else if (tgt_ok) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (32'(tgt) == c) begin
          unique case (off)
            LC_PEND:  rd_word = DATA_W'(pend_a[c]) << CMP_BIT;
            LC_MASK:  rd_word = DATA_W'(mask_a[c]);
            LC_MAP:   rd_word = (DATA_W'(route_a[c]) << ROUTE_BIT) |
                                DATA_W'(pin_a[c]);
            LC_OIDX:  rd_word = DATA_W'(oidx_a[c]);
            LC_IDENT: rd_word = DATA_W'(tgt);
            LC_CMP:   rd_word = DATA_W'(cmp_a[c]);
            default:  rd_word = '0;
          endcase
        end
      end
    end
  end

  assign rsp_valid_d = req_valid && !req_we;
  assign rd_en       = rsp_valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rd_en) rsp_rdata_q <= rd_word;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R11
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);

  // R3
  hi_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_addr == 5'h02) |=> rsp_rdata == '0);

endmodule

// File: tb/ctimer_top_bench.sv
module ctimer_top_bench;

  localparam int NC = 2;
  localparam int NP = 6;
  localparam int CW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_we = 1'b0;
  logic [CW-1:0] req_src = '0;
  logic [4:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NC*NP-1:0] router_irq = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC*NP-1:0] cpu_irq;

  ctimer_top #(.NUM_CORES(NC), .NUM_PINS(NP), .CNT_W(32)) u_ctimer_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
    .router_irq(router_irq), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cpu_irq(cpu_irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R11";

  // model state
  logic        mstop;
  logic [31:0] mcnt;
  logic [31:0] mcmp [NC];
  logic        mpend [NC];
  logic [5:0]  mmask [NC];
  logic        mroute [NC];
  logic [2:0]  mpin [NC];
  int          moidx [NC];
  logic        exp_valid;
  logic [31:0] exp_data;
  string       exp_tag;

  function automatic string tag_of(logic [4:0] a);
    if (a[4:3] == 2'd0) return (a[2:0] == 3'd0) ? "R2" : "R3";
    if (a[4:3] == 2'd3) return "R11";
    case (a[2:0])
      3'd0: return "R4";
      3'd1: return "R6";
      3'd4: return "R7";
      3'd5: return "R9";
      3'd6: return "R10";
      3'd7: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [NC*NP-1:0] exp_pins();
    logic [NC*NP-1:0] p;
    p = router_irq;
    for (int c = 0; c < NC; c++)
      if (mpend[c] && mmask[c][1] && mroute[c]) p[c*NP + int'(mpin[c])] = 1'b1;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstop = 0; mcnt = 0; exp_valid = 0; exp_data = 0; exp_tag = "";
      for (int c = 0; c < NC; c++) begin
        mcmp[c] = 32'hFFFF_FFFF; mpend[c] = 0; mmask[c] = 6'h32;
        mroute[c] = 1; mpin[c] = 0; moidx[c] = 0;
      end
    end else begin
      automatic logic [1:0] w = req_addr[4:3];
      automatic logic [2:0] o = req_addr[2:0];
      automatic int t = (w == 2'd2) ? moidx[int'(req_src)] : int'(req_src);
      automatic logic nstop = mstop;
      automatic logic [31:0] ncnt = mstop ? mcnt : mcnt + 1;
      automatic logic hitv [NC];
      automatic logic cw [NC];
      automatic logic [31:0] rd = 0;
      for (int c = 0; c < NC; c++) begin
        hitv[c] = !mstop && (mcnt == mcmp[c]);
        cw[c] = 0;
      end
      if (w == 2'd0) begin
        if (o == 3'd0) rd = {31'd0, mstop};
        else if (o == 3'd1) rd = mcnt;
      end else if (w != 2'd3) begin
        case (o)
          3'd0: rd = {30'd0, mpend[t], 1'b0};
          3'd1: rd = {26'd0, mmask[t]};
          3'd4: rd = {mroute[t], 28'd0, mpin[t]};
          3'd5: rd = 32'(moidx[t]);
          3'd6: rd = 32'(t);
          3'd7: rd = mcmp[t];
          default: rd = 0;
        endcase
      end
      exp_valid = req_valid && !req_we;
      if (exp_valid) begin exp_data = rd; exp_tag = {phase, "/", tag_of(req_addr)}; end
      if (req_valid && req_we) begin
        if (w == 2'd0) begin
          if (o == 3'd0) nstop = req_wdata[0];
          else if (o == 3'd1 && mstop) ncnt = req_wdata;
        end else if (w != 2'd3) begin
          case (o)
            3'd2: mmask[t] = mmask[t] | req_wdata[5:0];
            3'd3: mmask[t] = mmask[t] & ~req_wdata[5:0];
            3'd4: if (req_wdata[5:0] < NP) begin
                    mroute[t] = req_wdata[31]; mpin[t] = req_wdata[2:0];
                  end
            3'd5: if (req_wdata < NC) moidx[t] = int'(req_wdata);
            3'd7: begin mcmp[t] = req_wdata; cw[t] = 1; end
            default: ;
          endcase
        end
      end
      for (int c = 0; c < NC; c++)
        if (cw[c]) mpend[c] = 0;
        else if (hitv[c]) mpend[c] = 1;
      mstop = nstop; mcnt = ncnt;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      if (rsp_valid !== exp_valid) begin
        errors++; checks++;
        $display("FAIL R11 rsp_valid act=%0b exp=%0b", rsp_valid, exp_valid);
      end else if (exp_valid) begin
        checks++;
        if (rsp_rdata !== exp_data) begin
          errors++;
          $display("FAIL %s read act=%h exp=%h", exp_tag, rsp_rdata, exp_data);
        end
      end
      checks++;
      if (cpu_irq !== exp_pins()) begin
        errors++;
        $display("FAIL R7/R8 pins act=%b exp=%b", cpu_irq, exp_pins());
      end
    end
  end

  task automatic acc(bit we, int src, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_we = we; req_src = CW'(src); req_addr = a; req_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_we = 0;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state through reads
    phase = "R1";
    acc(0, 0, 5'h00, 0); acc(0, 0, 5'h02, 0);
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 8; o++) acc(0, c, 5'(8 + o), 0);
    acc(0, 0, 5'h01, 0);
    // R3 writes while running / high word
    phase = "R3";
    acc(1, 0, 5'h02, 32'h1234_5678); acc(0, 0, 5'h02, 0);
    acc(1, 0, 5'h01, 32'h0000_0100); acc(0, 0, 5'h01, 0);
    // R2 stop and load
    phase = "R2";
    acc(1, 0, 5'h00, 1); acc(1, 0, 5'h01, 100); acc(0, 0, 5'h01, 0);
    idle(3); acc(0, 1, 5'h01, 0); acc(0, 0, 5'h00, 0);
    // R9 other-core programming
    phase = "R9";
    acc(1, 0, 5'h0D, 1); acc(1, 0, 5'h0D, 3); acc(0, 0, 5'h0D, 0);
    acc(0, 0, 5'h16, 0);
    acc(1, 0, 5'h17, 105); acc(1, 1, 5'h0C, 32'h8000_0003);
    phase = "R4";
    acc(1, 0, 5'h0F, 110);
    acc(1, 0, 5'h00, 0); idle(20);
    acc(0, 0, 5'h08, 0); acc(0, 1, 5'h08, 0);
    // R6 mask ports
    phase = "R6";
    acc(1, 0, 5'h09, 6'h3F); acc(0, 0, 5'h09, 0);
    acc(1, 0, 5'h0B, 6'h02); acc(0, 0, 5'h09, 0); idle(2);
    acc(1, 0, 5'h0A, 6'h03); acc(0, 0, 5'h09, 0); idle(2);
    // R7 routing off and bad pin
    phase = "R7";
    acc(1, 1, 5'h0C, 32'h0000_0002); idle(2);
    acc(1, 1, 5'h0C, 32'h8000_0007); acc(0, 1, 5'h0C, 0);
    acc(1, 1, 5'h0C, 32'h8000_0005); idle(2);
    // R5 acknowledge
    phase = "R5";
    acc(1, 0, 5'h0F, 32'hFFFF_0000); acc(0, 0, 5'h08, 0);
    acc(1, 1, 5'h0F, 32'hFFFF_0000); acc(0, 1, 5'h08, 0);
    // R5 write on the match cycle
    acc(1, 0, 5'h00, 1); acc(1, 0, 5'h01, 200); acc(1, 0, 5'h0F, 203);
    acc(1, 0, 5'h00, 0); idle(3);
    acc(1, 0, 5'h0F, 32'h0000_1000); acc(0, 0, 5'h08, 0); idle(2);
    // R4 wrap: passed compare fires after wrap
    phase = "R4";
    acc(1, 0, 5'h00, 1); acc(1, 0, 5'h01, 32'hFFFF_FFF0);
    acc(1, 0, 5'h0F, 5); acc(1, 0, 5'h00, 0);
    idle(10); acc(0, 0, 5'h08, 0); idle(20); acc(0, 0, 5'h08, 0);
    // R10 identity and R11 empty window
    phase = "R10";
    acc(0, 1, 5'h0E, 0); acc(0, 0, 5'h0E, 0);
    phase = "R11";
    acc(0, 0, 5'h18, 0); acc(1, 0, 5'h1F, 0); acc(0, 0, 5'h03, 0);
    // R8 router merge and random mix
    phase = "R8";
    for (int i = 0; i < 4000; i++) begin
      automatic int r = int'($urandom_range(0, 99));
      automatic int src = int'($urandom_range(0, NC - 1));
      automatic logic [2:0] o = 3'($urandom_range(0, 7));
      automatic logic [1:0] w = 2'($urandom_range(0, 2));
      automatic logic [31:0] d = $urandom;
      if (r < 5) router_irq = NC*NP'($urandom) & NC*NP'($urandom);
      if (w == 2'd0) begin
        o = 3'($urandom_range(0, 2));
        if (o == 3'd0) d = ($urandom_range(0, 7) == 0) ? 1 : 0;
      end
      if (w != 2'd0 && o == 3'd7) d = mcnt + 32'($urandom_range(0, 40));
      if (w != 2'd0 && o == 3'd4) d = {d[31], 25'd0, 3'd0, 3'($urandom_range(0, 7))};
      if (w != 2'd0 && o == 3'd5) d = 32'($urandom_range(0, 3));
      if (r < 50) acc($urandom_range(0, 1) == 1, src, {w, o}, d);
      else idle(1);
    end
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule